// File: doc/BRIEF.md
# Deferred Coefficient Update Buffer

This block lets a host change filter coefficients while a processing core keeps reading its parameter memory. The host places up to five pending updates in staging slots. Each update is a parameter-memory address and a coefficient. A single commit pulse then starts a batch. The block moves the staged entries into the parameter memory through a single write port. It writes only in cycles that the core has not claimed, so the core's accesses are never delayed and a whole filter section changes as one group.

Coefficients are 28-bit two's complement values with 5 integer bits and 23 fraction bits. On the host side they arrive zero-extended to 32 bits, and the block drops the top four bits before storage. Only parameter-memory addresses can be staged. Any host address at or above the parameter-memory depth is refused, which covers program-memory, register and reserved space.

The core announces each memory access one cycle ahead on `core_claim`. A frame tick marks the audio frame boundary. A batch that is still running when the tick arrives is flagged, because a batch must finish inside the frame in which it was committed.

Top module: `coef_deferred_writer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done`, `pm_we`, `ld_ok`, `ld_err` and `frame_miss` are all low.
- R2: A load with `ld_valid` high while idle, with `ld_slot` below 5 and `ld_addr` below 1024, stages that entry and marks the slot valid. `ld_ok` pulses in the following cycle.
- R3: A load with `ld_addr` of 1024 or more (program, register or reserved space) is refused. `ld_err` pulses in the following cycle and nothing is staged.
- R4: A load with `ld_slot` of 5, 6 or 7 is refused with an `ld_err` pulse and stages nothing.
- R5: The coefficient written to memory equals bits 27:0 of the loaded host word. Bits 31:28 are discarded.
- R6: After a commit, the valid slots are written in ascending slot order, starting at slot 0. Each valid slot is written exactly once, slots that were not loaded are skipped, and `pm_we` is high only while `busy` is high.
- R7: `pm_we` is never high in the cycle after a cycle in which `core_claim` was high. An entry that cannot be written yet waits for the next unclaimed cycle.
- R8: `busy` rises in the cycle after a commit that finds at least one valid slot. A load attempted while `busy` is high gets `ld_err` and is not staged.
- R9: `done` is a one-cycle pulse in the cycle after the last write of a batch, and `busy` falls in that same cycle.
- R10: A commit with no valid slots gives a `done` pulse in the next cycle, with `busy` staying low and no write.
- R11: A `frame_tick` while `busy` is high gives a `frame_miss` pulse in the next cycle. A tick while idle gives none.
- R12: Loading a slot again before the commit replaces its earlier address and data.
- R13: A commit while a batch is running is ignored. The running batch neither restarts nor repeats a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Host load request for one staging slot |
| ld_slot | input | 3 | Staging slot index |
| ld_addr | input | 11 | Host address of the target coefficient |
| ld_data | input | 32 | Zero-extended coefficient word |
| ld_ok | output | 1 | Load accepted (one cycle after the request) |
| ld_err | output | 1 | Load refused (one cycle after the request) |
| commit | input | 1 | Start copying the valid slots |
| frame_tick | input | 1 | Audio frame boundary pulse |
| core_claim | input | 1 | Core uses the parameter memory in the next cycle |
| pm_we | output | 1 | Parameter-memory write enable |
| pm_addr | output | 10 | Parameter-memory write address |
| pm_wdata | output | 28 | Parameter-memory write data |
| busy | output | 1 | Batch in progress |
| done | output | 1 | Batch finished pulse |
| frame_miss | output | 1 | Frame boundary passed during a batch |

## Verification
The bench loads slots at the address edges 1023 and 1024, at the reserved range and at slot indices above 4. A design with an off-by-one range check would either put a program-memory address into the batch or drop a legal coefficient at the top of parameter space. It replays batches against alternating and long stretches of `core_claim`. A design that wrote on a claimed cycle, or that advanced past an entry it had not yet written, would show a write beside a claim or a missing address. Empty commits, loads and commits made during a batch, and frame ticks while busy and while idle are also driven. These catch a design that hangs on an empty batch, stages a load it should refuse, restarts a running batch, or raises a false frame overrun.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
  localparam int unsigned CDW_SLOTS    = 5;
  localparam int unsigned CDW_PM_DEPTH = 1024;
  localparam int unsigned CDW_HOST_AW  = 11;
  localparam int unsigned CDW_HOST_DW  = 32;
  localparam int unsigned CDW_COEF_W   = 28;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cdw_load_gate.sv
module cdw_load_gate
  import cdw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = CDW_SLOTS,
  parameter int unsigned PM_DEPTH  = CDW_PM_DEPTH,
  parameter int unsigned HOST_AW   = CDW_HOST_AW,
  parameter int unsigned HOST_DW   = CDW_HOST_DW,
  parameter int unsigned COEF_W    = CDW_COEF_W,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned PM_AW    = $clog2(PM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  input  logic [SLOT_W-1:0]  ld_slot,
  input  logic [HOST_AW-1:0] ld_addr,
  input  logic [HOST_DW-1:0] ld_data,
  input  logic               lock,
  output logic               wr_en,
  output logic [SLOT_W-1:0]  wr_idx,
  output logic [PM_AW-1:0]   wr_addr,
  output logic [COEF_W-1:0]  wr_data,
  output logic               ok_q,
  output logic               err_q
);
  localparam logic [SLOT_W:0]    SLOT_LIM = (SLOT_W+1)'(NUM_SLOTS);
  localparam logic [HOST_AW-1:0] ADDR_LIM = HOST_AW'(PM_DEPTH);

  logic slot_ok;
  logic addr_ok;
  logic pad_unused;

  assign slot_ok    = {1'b0, ld_slot} < SLOT_LIM;
  assign addr_ok    = ld_addr < ADDR_LIM;
  assign pad_unused = ^ld_data[HOST_DW-1:COEF_W];

  assign wr_en   = ld_valid && !lock && slot_ok && addr_ok;
  assign wr_idx  = ld_slot;
  assign wr_addr = ld_addr[PM_AW-1:0];
  assign wr_data = ld_data[COEF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ok_q  <= wr_en;
      err_q <= ld_valid && !wr_en;
    end
  end

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> ($past(ld_addr) < ADDR_LIM));

  // R2
  ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ok_q && err_q));
endmodule

// File: rtl/cdw_slot_bank.sv
module cdw_slot_bank
  import cdw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = CDW_SLOTS,
  parameter int unsigned AW        = $clog2(CDW_PM_DEPTH),
  parameter int unsigned DW        = CDW_COEF_W,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_idx,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 clr_en,
  input  logic [SLOT_W-1:0]    clr_idx,
  input  logic [SLOT_W-1:0]    rd_idx,
  output logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic [NUM_SLOTS-1:0] valid
);
  logic [AW+DW-1:0] mem [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_addr, wr_data};
  end

  assign {rd_addr, rd_data} = mem[rd_idx];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                        valid[s] <= 1'b0;
      else if (wr_en  && (wr_idx  == SLOT_W'(s)))     valid[s] <= 1'b1;
      else if (clr_en && (clr_idx == SLOT_W'(s)))     valid[s] <= 1'b0;
    end
  end

  // R6
  clear_only_full_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> valid[clr_idx]);

  // R8
  no_load_during_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && clr_en));
endmodule

// File: rtl/cdw_picker.sv
module cdw_picker
  import cdw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = CDW_SLOTS,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] valid,
  output logic                 found,
  output logic [SLOT_W-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (valid[i]) begin
        found = 1'b1;
        idx   = i[SLOT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cdw_sequencer.sv
module cdw_sequencer
  import cdw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = CDW_SLOTS,
  parameter int unsigned AW        = $clog2(CDW_PM_DEPTH),
  parameter int unsigned DW        = CDW_COEF_W,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              frame_tick,
  input  logic              core_claim,
  input  logic              found,
  input  logic [SLOT_W-1:0] pick_idx,
  input  logic [AW-1:0]     rd_addr,
  input  logic [DW-1:0]     rd_data,
  output logic              clr_en,
  output logic [SLOT_W-1:0] clr_idx,
  output logic              pm_we,
  output logic [AW-1:0]     pm_addr,
  output logic [DW-1:0]     pm_wdata,
  output logic              busy,
  output logic              done,
  output logic              frame_miss
);
  seq_state_e state_q;

  assign busy    = (state_q == ST_RUN);
  assign clr_en  = busy && found && !core_claim;
  assign clr_idx = pick_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      pm_we      <= 1'b0;
      pm_addr    <= '0;
      pm_wdata   <= '0;
      done       <= 1'b0;
      frame_miss <= 1'b0;
    end else begin
      pm_we      <= clr_en;
      done       <= 1'b0;
      frame_miss <= frame_tick && busy;
      if (clr_en) begin
        pm_addr  <= rd_addr;
        pm_wdata <= rd_data;
      end
      case (state_q)
        ST_IDLE: begin
          if (commit) begin
            if (found) state_q <= ST_RUN;
            else       done    <= 1'b1;
          end
        end
        ST_RUN: begin
          if (!found) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  empty_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !busy && !found) |=> (done && !busy));

  // R6
  write_in_batch_chk: assert property (@(posedge clk) disable iff (rst)
    pm_we |-> busy);
endmodule

// File: rtl/coef_deferred_writer.sv
module coef_deferred_writer
  import cdw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = CDW_SLOTS,
  parameter int unsigned PM_DEPTH  = CDW_PM_DEPTH,
  parameter int unsigned HOST_AW   = CDW_HOST_AW,
  parameter int unsigned HOST_DW   = CDW_HOST_DW,
  parameter int unsigned COEF_W    = CDW_COEF_W,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned PM_AW    = $clog2(PM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  input  logic [SLOT_W-1:0]  ld_slot,
  input  logic [HOST_AW-1:0] ld_addr,
  input  logic [HOST_DW-1:0] ld_data,
  output logic               ld_ok,
  output logic               ld_err,
  input  logic               commit,
  input  logic               frame_tick,
  input  logic               core_claim,
  output logic               pm_we,
  output logic [PM_AW-1:0]   pm_addr,
  output logic [COEF_W-1:0]  pm_wdata,
  output logic               busy,
  output logic               done,
  output logic               frame_miss
);
  logic                 wr_en;
  logic [SLOT_W-1:0]    wr_idx;
  logic [PM_AW-1:0]     wr_addr;
  logic [COEF_W-1:0]    wr_data;
  logic                 clr_en;
  logic [SLOT_W-1:0]    clr_idx;
  logic [SLOT_W-1:0]    pick_idx;
  logic                 found;
  logic [PM_AW-1:0]     rd_addr;
  logic [COEF_W-1:0]    rd_data;
  logic [NUM_SLOTS-1:0] valid;

  cdw_load_gate #(
    .NUM_SLOTS(NUM_SLOTS), .PM_DEPTH(PM_DEPTH), .HOST_AW(HOST_AW),
    .HOST_DW(HOST_DW), .COEF_W(COEF_W)
  ) u_gate (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_slot(ld_slot),
    .ld_addr(ld_addr), .ld_data(ld_data), .lock(busy),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_data(wr_data),
    .ok_q(ld_ok), .err_q(ld_err)
  );

  cdw_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .AW(PM_AW), .DW(COEF_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_addr(wr_addr), .wr_data(wr_data), .clr_en(clr_en),
    .clr_idx(clr_idx), .rd_idx(pick_idx), .rd_addr(rd_addr),
    .rd_data(rd_data), .valid(valid)
  );

  cdw_picker #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .valid(valid), .found(found), .idx(pick_idx)
  );

  cdw_sequencer #(.NUM_SLOTS(NUM_SLOTS), .AW(PM_AW), .DW(COEF_W)) u_seq (
    .clk(clk), .rst(rst), .commit(commit), .frame_tick(frame_tick),
    .core_claim(core_claim), .found(found), .pick_idx(pick_idx),
    .rd_addr(rd_addr), .rd_data(rd_data), .clr_en(clr_en),
    .clr_idx(clr_idx), .pm_we(pm_we), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .busy(busy), .done(done), .frame_miss(frame_miss)
  );

  // R7
  core_first_chk: assert property (@(posedge clk) disable iff (rst)
    core_claim |=> !pm_we);

  // R8
  busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ld_valid) |=> (ld_err && !ld_ok));
endmodule

// File: tb/coef_deferred_writer_tb.sv
module coef_deferred_writer_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid, commit, frame_tick, core_claim;
  logic [2:0]  ld_slot;
  logic [10:0] ld_addr;
  logic [31:0] ld_data;
  logic        ld_ok, ld_err, pm_we, busy, done, frame_miss;
  logic [9:0]  pm_addr;
  logic [27:0] pm_wdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic        exp_v [5];
  logic [9:0]  exp_a [5];
  logic [27:0] exp_d [5];

  // {slot, addr, data, accept}
  localparam logic [46:0] LOADS [8] = '{
    {3'd0, 11'h010, 32'h0080_0000, 1'b1},
    {3'd2, 11'h3FF, 32'hF123_4567, 1'b1},
    {3'd1, 11'h400, 32'h0000_0001, 1'b0},
    {3'd5, 11'h020, 32'h0000_0002, 1'b0},
    {3'd4, 11'h000, 32'h0FFF_FFFF, 1'b1},
    {3'd2, 11'h155, 32'h0ABC_DEF0, 1'b1},
    {3'd7, 11'h7FF, 32'h0000_0003, 1'b0},
    {3'd3, 11'h600, 32'h0000_0004, 1'b0}
  };

  always #5 clk = ~clk;

  coef_deferred_writer u_dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_slot(ld_slot),
    .ld_addr(ld_addr), .ld_data(ld_data), .ld_ok(ld_ok), .ld_err(ld_err),
    .commit(commit), .frame_tick(frame_tick), .core_claim(core_claim),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata), .busy(busy),
    .done(done), .frame_miss(frame_miss)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] s, input logic [10:0] a,
                      input logic [31:0] d, input bit accept, input string req);
    ld_valid = 1'b1; ld_slot = s; ld_addr = a; ld_data = d;
    tick;
    ld_valid = 1'b0;
    chk({req, " ld_ok"}, 32'(ld_ok), 32'(accept));
    chk({req, " ld_err"}, 32'(ld_err), 32'(!accept));
    if (accept) begin
      exp_v[s] = 1'b1; exp_a[s] = a[9:0]; exp_d[s] = d[27:0];
    end
  endtask

  // mode 0: core idle, 1: claim on alternate cycles, 2: claim held for 8 cycles
  task automatic run_batch(input int mode, input bit disturb);
    logic [9:0]  qa [5];
    logic [27:0] qd [5];
    int n = 0;
    int got = 0;
    bit seen = 1'b0;
    for (int s = 0; s < 5; s++) begin
      if (exp_v[s]) begin qa[n] = exp_a[s]; qd[n] = exp_d[s]; n++; end
    end
    commit = 1'b1;
    tick;
    commit = 1'b0;
    if (n == 0) begin
      chk("R10 done after empty commit", 32'(done), 32'd1);
      chk("R10 busy stays low", 32'(busy), 32'd0);
      chk("R10 no write", 32'(pm_we), 32'd0);
      tick;
      chk("R9 done one cycle", 32'(done), 32'd0);
      return;
    end
    chk("R8 busy after commit", 32'(busy), 32'd1);
    for (int c = 0; c < 60 && !seen; c++) begin
      core_claim = (mode == 1) ? c[0] : (mode == 2) ? (c < 8) : 1'b0;
      if (disturb && c == 0) begin
        ld_valid = 1'b1; ld_slot = 3'd4; ld_addr = 11'h0AA; ld_data = 32'h0123_4567;
        commit = 1'b1;
      end
      if (mode == 2 && c == 3) frame_tick = 1'b1;
      tick;
      ld_valid = 1'b0; commit = 1'b0; frame_tick = 1'b0;
      if (disturb && c == 0) chk("R8 load refused while busy", 32'(ld_err), 32'd1);
      if (mode == 2 && c == 3) chk("R11 frame_miss while busy", 32'(frame_miss), 32'd1);
      if (core_claim) chk("R7 no write after claim", 32'(pm_we), 32'd0);
      if (pm_we) begin
        if (got < n) begin
          chk("R6 write address order", 32'(pm_addr), 32'(qa[got]));
          chk("R5 write data stripped", 32'(pm_wdata), 32'(qd[got]));
        end else begin
          chk("R13 extra write", 32'(got), 32'(n - 1));
        end
        got++;
      end
      if (done) begin
        seen = 1'b1;
        chk("R9 busy falls with done", 32'(busy), 32'd0);
        chk("R6 write count", 32'(got), 32'(n));
      end
    end
    core_claim = 1'b0;
    chk("R9 done reached", 32'(seen), 32'd1);
    tick;
    chk("R9 done one cycle", 32'(done), 32'd0);
    chk("R11 no stray frame_miss", 32'(frame_miss), 32'd0);
    for (int s = 0; s < 5; s++) exp_v[s] = 1'b0;
  endtask

  initial begin
    rst = 1'b1; ld_valid = 1'b0; commit = 1'b0; frame_tick = 1'b0;
    core_claim = 1'b0; ld_slot = '0; ld_addr = '0; ld_data = '0;
    for (int s = 0; s < 5; s++) begin exp_v[s] = 1'b0; exp_a[s] = '0; exp_d[s] = '0; end
    repeat (3) tick;
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 pm_we in reset", 32'(pm_we), 32'd0);
    chk("R1 acks in reset", 32'({ld_ok, ld_err, frame_miss}), 32'd0);
    rst = 1'b0;
    tick;
    chk("R1 idle after reset", 32'({busy, done, pm_we}), 32'd0);

    // R2 R3 R4 R12: table of loads
    for (int i = 0; i < 8; i++) begin
      load(LOADS[i][46:44], LOADS[i][43:33], LOADS[i][32:1], LOADS[i][0], "R2/R3/R4 table load");
    end
    run_batch(1, 1'b0);
    run_batch(0, 1'b0);

    // R8 R13: load and commit during a batch
    load(3'd1, 11'h201, 32'h0000_1111, 1'b1, "R2 load");
    load(3'd3, 11'h202, 32'h0000_2222, 1'b1, "R2 load");
    run_batch(0, 1'b1);
    run_batch(0, 1'b0);

    // R11 R7: long claim with frame tick during batch
    load(3'd4, 11'h3FE, 32'h0FFF_0000, 1'b1, "R2 load");
    load(3'd0, 11'h001, 32'hA000_0001, 1'b1, "R5 load padded");
    run_batch(2, 1'b0);

    frame_tick = 1'b1;
    tick;
    frame_tick = 1'b0;
    chk("R11 tick while idle", 32'(frame_miss), 32'd0);

    load(3'd6, 11'h010, 32'h0, 1'b0, "R4 slot 6");
    load(3'd0, 11'h400, 32'h0, 1'b0, "R3 addr 1024");
    run_batch(0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule